// File: doc/BRIEF.md
# EDAC Read Sequencer with Error Logging

This block runs the read side of a memory protected by a 16-bit data, 6-bit check-word error detection and correction codec. The codec is wired as a decoder only, because a second codec instance encodes on writes. When the CPU asks for a read, the sequencer drives the decoder's two mode pins through a fixed order: pass-through, then latch, then an optional correct step. It samples the decoder's single-error and dual-error flags. It then returns either the raw memory word or the decoder's corrected word.

An uncorrectable (dual) error returns no data. It raises an interrupt that stays high until the CPU acknowledges it. A sticky status register logs which kinds of error have been seen and the last syndrome. A run counter watches for the same syndrome on consecutive erroneous reads. When that run reaches a set length, the counter raises a hard-fault indication that points at one failing memory device.

Top module: `edacReadSeq`

## Requirements
- R1: The mode output `codecCtl` uses bit 1 as the latch control and bit 0 as the pass control. It reads 2'b01 out of reset, while idle, and in every cycle after a read request until `memValid` is seen. It never reads 2'b00.
- R2: After `memValid` is sampled, `codecCtl` reads 2'b11 for exactly SETTLE+1 cycles: the latch dwell plus one evaluate cycle. The flags are sampled at the end of the evaluate cycle.
- R3: If neither flag is set at evaluation, the next cycle shows `cpuData` equal to `memWord` with `cpuValid` high for one cycle. No correct step (2'b10) occurs.
- R4: If `flagSingle` is high and `flagDouble` is low at evaluation, `codecCtl` reads 2'b10 for SETTLE cycles. The next cycle shows `cpuData` equal to `codecData` as it stood during that step, with `cpuValid` high for one cycle.
- R5: If `flagDouble` is high at evaluation, `cpuValid` stays low and `irq` rises. `irq` stays high until `irqAck` is sampled high, and it clears on that edge.
- R6: `statSingle` is set by a corrected read and `statDouble` by a dual-error read. Both are sticky, clean reads leave them unchanged, and a `statClr` pulse clears them together with `statSyn` and `hardFault`.
- R7: A corrected read stores `codecSyn` in `statSyn`. `hardFault` sets when the same syndrome appears on HARD_REPEAT (default 3) consecutive erroneous reads. Clean reads do not break the run. A different syndrome restarts the run, and a dual-error read zeroes it. `hardFault` is sticky until `statClr`.
- R8: A corrected read whose syndrome is all ones still returns corrected data and sets `statSingle`. It changes neither `statSyn` nor the repeat run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | CPU read request, sampled while idle |
| memValid | input | 1 | Memory word and check word are valid |
| memWord | input | 16 | Raw data word from memory |
| codecCtl | output | 2 | Decoder mode pins {latch, pass} |
| flagSingle | input | 1 | Decoder single-error flag |
| flagDouble | input | 1 | Decoder dual-error flag |
| codecData | input | 16 | Corrected word from the decoder |
| codecSyn | input | 6 | Syndrome from the decoder's check-word port |
| cpuData | output | 16 | Word returned to the CPU |
| cpuValid | output | 1 | One-cycle pulse: cpuData is valid |
| irq | output | 1 | Dual-error interrupt, held until acknowledged |
| irqAck | input | 1 | Interrupt acknowledge |
| statClr | input | 1 | Clears status and hard-fault tracking |
| statSingle | output | 1 | A corrected read has occurred |
| statDouble | output | 1 | A dual-error read has occurred |
| statSyn | output | 6 | Last valid syndrome |
| hardFault | output | 1 | Repeated-syndrome hard fault |

## Verification
Clean reads use several data patterns, including all zeros, all ones, alternating bits and a walking one. Raw data delivery is told apart from corrected delivery by making the decoder's corrected port differ from memory. Corrected reads sweep every one of the 63 valid syndromes back to back. This shows that distinct syndromes never build a run, and that each one reaches the status register. Short syndrome sequences then separate the run rules: a clean read in between, a different syndrome, a dual error, and an all-ones syndrome. A delayed `memValid` shows the pass-through phase holding.

// File: rtl/edacSeqPkg.sv
package edacSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LATCH,
    ST_EVAL,
    ST_CORRECT,
    ST_DONE,
    ST_FAULT
  } seqState_t;

  typedef struct packed {
    logic capRaw;     // take memory word as result
    logic capCorr;    // take corrected word, log syndrome
    logic logDouble;  // dual error: interrupt and log
  } seqStrobe_t;

  localparam logic [1:0] CTL_PASS    = 2'b01;
  localparam logic [1:0] CTL_LATCH   = 2'b11;
  localparam logic [1:0] CTL_CORRECT = 2'b10;

endpackage

// File: rtl/edacSeqCtrl.sv
module edacSeqCtrl
  import edacSeqPkg::*;
#(
  parameter int SETTLE = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       memValid,
  input  logic       flagSingle,
  input  logic       flagDouble,
  output logic [1:0] codecCtl,
  output logic       cpuValid,
  output seqStrobe_t strobe
);

  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE - 1);

  seqState_t state, nextState;
  logic [CNT_W-1:0] dwellCnt, nextCnt;
  logic dwellDone;

  assign dwellDone = (dwellCnt == '0);

  always_comb begin
    nextState = state;
    nextCnt   = dwellCnt;
    strobe    = '0;
    unique case (state)
      ST_IDLE:  if (rdReq) nextState = ST_START;
      ST_START: if (memValid) begin
        nextState = ST_LATCH;
        nextCnt   = CNT_LOAD;
      end
      ST_LATCH: begin
        if (dwellDone) nextState = ST_EVAL;
        else nextCnt = dwellCnt - CNT_W'(1);
      end
      ST_EVAL: begin
        if (flagDouble) begin
          nextState        = ST_FAULT;
          strobe.logDouble = 1'b1;
        end else if (flagSingle) begin
          nextState = ST_CORRECT;
          nextCnt   = CNT_LOAD;
        end else begin
          nextState     = ST_DONE;
          strobe.capRaw = 1'b1;
        end
      end
      ST_CORRECT: begin
        if (dwellDone) begin
          nextState      = ST_DONE;
          strobe.capCorr = 1'b1;
        end else nextCnt = dwellCnt - CNT_W'(1);
      end
      ST_DONE:  nextState = ST_IDLE;
      ST_FAULT: nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dwellCnt <= '0;
    end else begin
      state    <= nextState;
      dwellCnt <= nextCnt;
    end
  end

  always_comb begin
    unique case (state)
      ST_LATCH, ST_EVAL: codecCtl = CTL_LATCH;
      ST_CORRECT:        codecCtl = CTL_CORRECT;
      default:           codecCtl = CTL_PASS;
    endcase
  end

  assign cpuValid = (state == ST_DONE);

  // R1: the decoder is never put into encode mode
  assert_never_encode_R1: assert property (@(posedge clk) disable iff (!rstN)
    codecCtl != 2'b00);

  // R1: waiting for memory keeps the pass-through mode
  assert_start_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && !memValid) |=> (codecCtl == CTL_PASS));

  // R4: a correct step always follows a latched cycle
  assert_correct_after_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (codecCtl == CTL_CORRECT) |-> $past(codecCtl[1]));

  // R3: result valid is a single-cycle pulse
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |=> !cpuValid);

endmodule

// File: rtl/edacSeqPath.sv
module edacSeqPath
  import edacSeqPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYN_W       = 6,
  parameter int HARD_REPEAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] memWord,
  input  logic [DATA_W-1:0] codecData,
  input  logic [SYN_W-1:0]  codecSyn,
  input  logic              irqAck,
  input  logic              statClr,
  output logic [DATA_W-1:0] cpuData,
  output logic              irq,
  output logic              statSingle,
  output logic              statDouble,
  output logic [SYN_W-1:0]  statSyn,
  output logic              hardFault
);

  localparam int RUN_W = $clog2(HARD_REPEAT + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HARD_REPEAT);

  logic [RUN_W-1:0] runCnt, nextRun;
  logic [SYN_W-1:0] lastSyn;
  logic synValid, sameSyn;

  assign synValid = (codecSyn != '1);
  assign sameSyn  = (runCnt != '0) && (codecSyn == lastSyn);

  always_comb begin
    if (sameSyn) nextRun = (runCnt == RUN_MAX) ? runCnt : runCnt + RUN_W'(1);
    else nextRun = RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuData <= '0;
    end else if (strobe.capRaw) begin
      cpuData <= memWord;
    end else if (strobe.capCorr) begin
      cpuData <= codecData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else if (strobe.logDouble) irq <= 1'b1;
    else if (irqAck) irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statSingle <= 1'b0;
      statDouble <= 1'b0;
      statSyn    <= '0;
      lastSyn    <= '0;
      runCnt     <= '0;
      hardFault  <= 1'b0;
    end else begin
      if (statClr) begin
        statSingle <= 1'b0;
        statDouble <= 1'b0;
        statSyn    <= '0;
        runCnt     <= '0;
        hardFault  <= 1'b0;
      end
      if (strobe.capCorr) begin
        statSingle <= 1'b1;
        if (synValid) begin
          statSyn <= codecSyn;
          lastSyn <= codecSyn;
          runCnt  <= nextRun;
          if (nextRun == RUN_MAX) hardFault <= 1'b1;
        end
      end
      if (strobe.logDouble) begin
        statDouble <= 1'b1;
        runCnt     <= '0;
      end
    end
  end

  // R5: interrupt holds until acknowledged
  assert_irq_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqAck) |=> irq);

  // R7: a hard fault only ever appears alongside a logged corrected read
  assert_hard_needs_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hardFault) |-> statSingle);

  // R6: sticky flags drop only on a clear request
  assert_sticky_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statSingle) |-> $past(statClr));

endmodule

// File: rtl/edacReadSeq.sv
module edacReadSeq
  import edacSeqPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYN_W       = 6,
  parameter int SETTLE      = 1,
  parameter int HARD_REPEAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memWord,
  output logic [1:0]        codecCtl,
  input  logic              flagSingle,
  input  logic              flagDouble,
  input  logic [DATA_W-1:0] codecData,
  input  logic [SYN_W-1:0]  codecSyn,
  output logic [DATA_W-1:0] cpuData,
  output logic              cpuValid,
  output logic              irq,
  input  logic              irqAck,
  input  logic              statClr,
  output logic              statSingle,
  output logic              statDouble,
  output logic [SYN_W-1:0]  statSyn,
  output logic              hardFault
);

  seqStrobe_t strobe;

  edacSeqCtrl #(.SETTLE(SETTLE)) uCtrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .memValid(memValid),
    .flagSingle(flagSingle), .flagDouble(flagDouble),
    .codecCtl(codecCtl), .cpuValid(cpuValid), .strobe(strobe)
  );

  edacSeqPath #(.DATA_W(DATA_W), .SYN_W(SYN_W), .HARD_REPEAT(HARD_REPEAT)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memWord(memWord),
    .codecData(codecData), .codecSyn(codecSyn), .irqAck(irqAck),
    .statClr(statClr), .cpuData(cpuData), .irq(irq),
    .statSingle(statSingle), .statDouble(statDouble), .statSyn(statSyn),
    .hardFault(hardFault)
  );

endmodule

// File: tb/tb_edacReadSeq.sv
module tb_edacReadSeq;

  localparam int SETTLE = 1;
  localparam int HARD_REPEAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdReq = 1'b0, memValid = 1'b0, irqAck = 1'b0, statClr = 1'b0;
  logic [15:0] trueWord = '0, errMask = '0;
  int scenKind = 0;
  logic [5:0] scenSyn = '1;

  logic [1:0] codecCtl;
  logic [15:0] memWord, codecData, cpuData;
  logic [5:0] codecSyn, statSyn;
  logic flagSingle, flagDouble, cpuValid, irq, statSingle, statDouble, hardFault;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  // decoder model: flags while latched, corrected word and syndrome while correcting
  assign memWord    = trueWord ^ errMask;
  assign flagSingle = codecCtl[1] && (scenKind != 0);
  assign flagDouble = codecCtl[1] && (scenKind == 2);
  assign codecData  = (codecCtl == 2'b10) ? trueWord : 16'h0000;
  assign codecSyn   = (codecCtl == 2'b10) ? scenSyn : 6'h3F;

  edacReadSeq #(.SETTLE(SETTLE), .HARD_REPEAT(HARD_REPEAT)) dut (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .memValid(memValid), .memWord(memWord),
    .codecCtl(codecCtl), .flagSingle(flagSingle), .flagDouble(flagDouble),
    .codecData(codecData), .codecSyn(codecSyn), .cpuData(cpuData), .cpuValid(cpuValid),
    .irq(irq), .irqAck(irqAck), .statClr(statClr), .statSingle(statSingle),
    .statDouble(statDouble), .statSyn(statSyn), .hardFault(hardFault)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 clean, 1 single, 2 double
  task automatic doRead(input logic [15:0] word, input int kind, input logic [5:0] syn, input int gap,
                        output logic [15:0] got, output bit gotValid, output bit gotIrq,
                        output int n11, output int n10, output bit startOk);
    @(negedge clk);
    trueWord = word;
    scenKind = kind;
    scenSyn  = syn;
    errMask  = (kind == 0) ? 16'h0 : (kind == 1) ? (16'h1 << syn[3:0]) : 16'h0003;
    rdReq = 1'b1;
    memValid = 1'b0;
    @(negedge clk);
    rdReq = 1'b0;
    startOk = 1'b1;
    for (int i = 0; i < gap; i++) begin
      if (codecCtl != 2'b01 || cpuValid) startOk = 1'b0;
      @(negedge clk);
    end
    if (codecCtl != 2'b01) startOk = 1'b0;
    memValid = 1'b1;
    n11 = 0; n10 = 0; gotValid = 1'b0; gotIrq = 1'b0; got = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (codecCtl == 2'b11) n11++;
      if (codecCtl == 2'b10) n10++;
      if (cpuValid) begin gotValid = 1'b1; got = cpuData; break; end
      if (irq) begin gotIrq = 1'b1; break; end
    end
    memValid = 1'b0;
    errMask = '0;
  endtask

  task automatic clearStat();
    @(negedge clk);
    statClr = 1'b1;
    @(negedge clk);
    statClr = 1'b0;
  endtask

  task automatic singleRead(input logic [15:0] word, input logic [5:0] syn, input string tag);
    logic [15:0] got; bit v, q, s; int a, b;
    doRead(word, 1, syn, 0, got, v, q, a, b, s);
    check(v && got == word, {tag, " R4 corrected data"}, {15'h0, v, got}, {16'h1, word});
    check(b == SETTLE, {tag, " R4 correct-step length"}, b, SETTLE);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL R2 watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] got; bit v, q, s; int a, b;
    logic [15:0] pats [0:3];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5A5; pats[3] = 16'h5A5A;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R6 reset state
    check(codecCtl == 2'b01, "R1 reset mode", codecCtl, 2'b01);
    check(!cpuValid && !irq, "R5 reset outputs", {cpuValid, irq}, 0);
    check(!statSingle && !statDouble && statSyn == 0 && !hardFault, "R6 reset status",
          {statSingle, statDouble, statSyn, hardFault}, 0);

    // R3 clean reads, fixed patterns then walking one
    for (int k = 0; k < 20; k++) begin
      logic [15:0] w;
      w = (k < 4) ? pats[k] : (16'h1 << (k - 4));
      doRead(w, 0, 6'h3F, 0, got, v, q, a, b, s);
      check(v && got == w, "R3 raw data", {15'h0, v, got}, {16'h1, w});
      check(b == 0, "R3 no correct step", b, 0);
      check(a == SETTLE + 1, "R2 latch cycles", a, SETTLE + 1);
      @(negedge clk);
      check(!cpuValid, "R3 valid single pulse", cpuValid, 0);
    end
    check(!statSingle && !statDouble && !hardFault, "R6 clean reads leave status",
          {statSingle, statDouble, hardFault}, 0);

    // R1 delayed memory valid
    doRead(16'h1234, 0, 6'h3F, 5, got, v, q, a, b, s);
    check(s, "R1 pass mode held while waiting", s, 1);
    check(v && got == 16'h1234, "R3 delayed read data", got, 16'h1234);

    // R4 / R7 sweep all valid syndromes back to back
    for (int k = 0; k < 63; k++) begin
      logic [15:0] w;
      w = 16'(k * 16'h0413) ^ 16'h5A5A;
      singleRead(w, 6'(k), "sweep");
      check(statSyn == 6'(k) && statSingle, "R7 syndrome logged", {statSingle, statSyn}, {1'b1, 6'(k)});
      check(!hardFault, "R7 distinct syndromes no fault", hardFault, 0);
    end

    // R6 clear
    clearStat();
    check(!statSingle && !statDouble && statSyn == 0 && !hardFault, "R6 clear status",
          {statSingle, statDouble, statSyn, hardFault}, 0);

    // R7 clean read between repeats does not break run
    singleRead(16'hBEEF, 6'h15, "run");
    singleRead(16'hBEEF, 6'h15, "run");
    check(!hardFault, "R7 two repeats no fault", hardFault, 0);
    doRead(16'h0F0F, 0, 6'h3F, 0, got, v, q, a, b, s);
    singleRead(16'hBEEF, 6'h15, "run");
    check(hardFault, "R7 three repeats fault", hardFault, 1);
    doRead(16'h0F0F, 0, 6'h3F, 0, got, v, q, a, b, s);
    check(hardFault, "R7 fault sticky", hardFault, 1);
    clearStat();
    check(!hardFault, "R7 fault cleared", hardFault, 0);

    // R7 different syndrome restarts run
    singleRead(16'h1111, 6'h15, "diff");
    singleRead(16'h1111, 6'h15, "diff");
    singleRead(16'h1111, 6'h2A, "diff");
    singleRead(16'h1111, 6'h15, "diff");
    check(!hardFault, "R7 different syndrome restarts", hardFault, 0);
    singleRead(16'h1111, 6'h15, "diff");
    singleRead(16'h1111, 6'h15, "diff");
    check(hardFault, "R7 new run reaches limit", hardFault, 1);
    clearStat();

    // R5 dual error
    singleRead(16'h2222, 6'h15, "dbl");
    singleRead(16'h2222, 6'h15, "dbl");
    doRead(16'h3333, 2, 6'h3F, 0, got, v, q, a, b, s);
    check(q && !v, "R5 dual raises irq, no data", {v, q}, 2'b01);
    check(statDouble, "R6 dual logged", statDouble, 1);
    repeat (5) @(negedge clk);
    check(irq, "R5 irq held", irq, 1);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    check(!irq, "R5 irq acknowledged", irq, 0);
    singleRead(16'h2222, 6'h15, "dbl");
    check(!hardFault, "R7 dual error zeroes run", hardFault, 0);
    check(statDouble && statSingle, "R6 flags sticky", {statDouble, statSingle}, 2'b11);
    clearStat();

    // R8 all-ones syndrome ignored by tracking
    singleRead(16'h4444, 6'h0B, "ones");
    singleRead(16'h4444, 6'h0B, "ones");
    singleRead(16'h7777, 6'h3F, "ones R8");
    check(statSyn == 6'h0B, "R8 status syndrome kept", statSyn, 6'h0B);
    check(!hardFault, "R8 no fault yet", hardFault, 0);
    singleRead(16'h4444, 6'h0B, "ones");
    check(hardFault, "R8 run not broken", hardFault, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule